// File: doc/BRIEF.md
# Collapsing Fetch Alignment Buffer

This block builds one fetch group for a wide front end. Two instruction-cache banks are read in the same cycle. One returns the line that holds the fetch address and the other returns the next sequential line. Because either bank can hold the fetch address, an interchange stage first puts the two lines into program order. This gives eight candidate instruction slots.

A per-slot valid mask marks the slots that survive. The mask has slots cleared after predicted-taken branches. The block also discards every slot in the first line that lies before the fetch offset. A collapsing stage then packs the surviving slots to the left of the output window in program order and removes the holes between them. This means a fetch that starts partway into a line still fills the window, as a rotation would. The packed group, a count of the instructions in it, and a group-valid flag are registered once before they leave the block.

Top module: `collapse_fetch_buf`

## Requirements
- R1: When `bank_sel_i` is 0, the words of `bank0_line_i` are candidate slots 0..3 and the words of `bank1_line_i` are candidate slots 4..7. When `bank_sel_i` is 1, the two lines swap places. Word w of a line is bits [w*32 +: 32].
- R2: Candidate slots 0..3 whose index is below `off_i` are dropped, whatever their bit in `slot_vld_i` says.
- R3: Bit j of `slot_vld_i` marks candidate slot j (program order) as valid. Surviving slots appear in output slots 0 upward, in ascending candidate order, with no gaps. Output slot k is `grp_o[k*32 +: 32]`.
- R4: At most 4 instructions are emitted. Surviving slots beyond the fourth are dropped.
- R5: `grp_cnt_o` equals the number of instructions placed in the group, from 0 to 4.
- R6: Every output slot at or above `grp_cnt_o` reads as zero.
- R7: A group presented with `fetch_vld_i` high appears on the outputs, with `grp_vld_o` high, exactly one clock edge later.
- R8: After an edge where `fetch_vld_i` is low, `grp_vld_o` and `grp_cnt_o` are 0 and `grp_o` is all zeros.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | A fetch group is presented this cycle |
| bank_sel_i | input | 1 | Bank holding the fetch-address line (0 or 1) |
| off_i | input | 2 | Slot offset of the fetch address in its line |
| bank0_line_i | input | 128 | Four instruction words read from bank 0 |
| bank1_line_i | input | 128 | Four instruction words read from bank 1 |
| slot_vld_i | input | 8 | Per-candidate valid mask in program order |
| grp_vld_o | output | 1 | Registered group valid |
| grp_o | output | 128 | Packed, left-aligned instruction group |
| grp_cnt_o | output | 3 | Number of instructions in `grp_o` |

## Verification
The bench builds the block with its defaults: four 32-bit slots per line and eight candidates. This is small enough that every offset, both bank orders, sparse masks, and masks with more than four survivors can all be reached. Directed groups cover the following cases:
- aligned fetches, swapped bank order and misaligned starts;
- the interleaved A,B,C,E,G pattern;
- masks emptied by the offset.

A long run of random groups, mixed with idle cycles, then exercises the packing against a scoreboard.

// File: rtl/cfb_pkg.sv
`timescale 1ns/1ps
package cfb_pkg;
  typedef enum logic {
    ORDER_B0_FIRST = 1'b0,
    ORDER_B1_FIRST = 1'b1
  } bank_order_e;
endpackage

// File: rtl/cfb_xchg.sv
`timescale 1ns/1ps
module cfb_xchg
  import cfb_pkg::*;
#(
  parameter int SLOT_N = 4,
  parameter int INSN_W = 32
) (
  input  bank_order_e                  order_i,
  input  logic [SLOT_N*INSN_W-1:0]     bank0_i,
  input  logic [SLOT_N*INSN_W-1:0]     bank1_i,
  output logic [2*SLOT_N*INSN_W-1:0]   cand_o
);
  localparam int LINE_W = SLOT_N * INSN_W;

  logic [LINE_W-1:0] first_line, second_line;

  always_comb begin
    if (order_i == ORDER_B1_FIRST) begin
      first_line  = bank1_i;
      second_line = bank0_i;
    end else begin
      first_line  = bank0_i;
      second_line = bank1_i;
    end
  end

  assign cand_o = {second_line, first_line};
endmodule

// File: rtl/cfb_vmask.sv
`timescale 1ns/1ps
module cfb_vmask #(
  parameter int SLOT_N = 4,
  localparam int OFF_W  = $clog2(SLOT_N),
  localparam int CAND_N = 2 * SLOT_N
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CAND_N-1:0] mask_i,
  output logic [CAND_N-1:0] live_o
);
  for (genvar j = 0; j < CAND_N; j++) begin : g_slot
    if (j < SLOT_N) begin : g_first
      // slots ahead of the fetch address never survive
      assign live_o[j] = mask_i[j] && (OFF_W'(j) >= off_i);
    end else begin : g_next
      assign live_o[j] = mask_i[j];
    end
  end
endmodule

// File: rtl/cfb_collapse.sv
`timescale 1ns/1ps
module cfb_collapse #(
  parameter int SLOT_N = 4,
  parameter int INSN_W = 32,
  localparam int CAND_N = 2 * SLOT_N,
  localparam int RANK_W = $clog2(CAND_N + 1),
  localparam int CNT_W  = $clog2(SLOT_N + 1)
) (
  input  logic [CAND_N*INSN_W-1:0] cand_i,
  input  logic [CAND_N-1:0]        live_i,
  output logic [SLOT_N*INSN_W-1:0] grp_o,
  output logic [CNT_W-1:0]         cnt_o
);
  // rank[j] = live slots strictly before j
  logic [RANK_W-1:0] rank [CAND_N+1];

  assign rank[0] = '0;
  for (genvar j = 0; j < CAND_N; j++) begin : g_rank
    assign rank[j+1] = rank[j] + RANK_W'(live_i[j]);
  end

  for (genvar k = 0; k < SLOT_N; k++) begin : g_out
    always_comb begin
      grp_o[k*INSN_W +: INSN_W] = '0;
      for (int j = 0; j < CAND_N; j++) begin
        if (live_i[j] && rank[j] == RANK_W'(k))
          grp_o[k*INSN_W +: INSN_W] = grp_o[k*INSN_W +: INSN_W] | cand_i[j*INSN_W +: INSN_W];
      end
    end
  end

  assign cnt_o = (rank[CAND_N] > RANK_W'(SLOT_N)) ? CNT_W'(SLOT_N) : CNT_W'(rank[CAND_N]);
endmodule

// File: rtl/collapse_fetch_buf.sv
`timescale 1ns/1ps
module collapse_fetch_buf
  import cfb_pkg::*;
#(
  parameter int SLOT_N = 4,
  parameter int INSN_W = 32,
  localparam int OFF_W  = $clog2(SLOT_N),
  localparam int CAND_N = 2 * SLOT_N,
  localparam int CNT_W  = $clog2(SLOT_N + 1),
  localparam int LINE_W = SLOT_N * INSN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_vld_i,
  input  logic              bank_sel_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LINE_W-1:0] bank0_line_i,
  input  logic [LINE_W-1:0] bank1_line_i,
  input  logic [CAND_N-1:0] slot_vld_i,
  output logic              grp_vld_o,
  output logic [LINE_W-1:0] grp_o,
  output logic [CNT_W-1:0]  grp_cnt_o
);
  logic [CAND_N*INSN_W-1:0] cand;
  logic [CAND_N-1:0]        live;
  logic [LINE_W-1:0]        grp_d;
  logic [CNT_W-1:0]         cnt_d;

  cfb_xchg #(.SLOT_N(SLOT_N), .INSN_W(INSN_W)) u_xchg (
    .order_i (bank_order_e'(bank_sel_i)),
    .bank0_i (bank0_line_i),
    .bank1_i (bank1_line_i),
    .cand_o  (cand)
  );

  cfb_vmask #(.SLOT_N(SLOT_N)) u_vmask (
    .off_i  (off_i),
    .mask_i (slot_vld_i),
    .live_o (live)
  );

  cfb_collapse #(.SLOT_N(SLOT_N), .INSN_W(INSN_W)) u_collapse (
    .cand_i (cand),
    .live_i (live),
    .grp_o  (grp_d),
    .cnt_o  (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_vld_o <= 1'b0;
      grp_o     <= '0;
      grp_cnt_o <= '0;
    end else if (fetch_vld_i) begin
      grp_vld_o <= 1'b1;
      grp_o     <= grp_d;
      grp_cnt_o <= cnt_d;
    end else begin
      grp_vld_o <= 1'b0;
      grp_o     <= '0;
      grp_cnt_o <= '0;
    end
  end
endmodule

// File: rtl/cfb_chk.sv
`timescale 1ns/1ps
module cfb_chk #(
  parameter int SLOT_N = 4,
  parameter int INSN_W = 32,
  localparam int OFF_W  = $clog2(SLOT_N),
  localparam int CAND_N = 2 * SLOT_N,
  localparam int CNT_W  = $clog2(SLOT_N + 1),
  localparam int LINE_W = SLOT_N * INSN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_vld_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [CAND_N-1:0] slot_vld_i,
  input logic              grp_vld_o,
  input logic [LINE_W-1:0] grp_o,
  input logic [CNT_W-1:0]  grp_cnt_o
);
  logic [SLOT_N-1:0] below_off;
  logic [CAND_N-1:0] eff;
  int                eff_n;
  logic [CNT_W-1:0]  exp_cnt_q;

  assign below_off = (SLOT_N'(1) << off_i) - SLOT_N'(1);
  assign eff       = slot_vld_i & ~{{SLOT_N{1'b0}}, below_off};
  assign eff_n     = $countones(eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_cnt_q <= '0;
    else         exp_cnt_q <= (eff_n > SLOT_N) ? CNT_W'(SLOT_N) : CNT_W'(eff_n);
  end

  // R7
  grp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_i |=> grp_vld_o);

  // R8
  idle_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_i |=> (!grp_vld_o && grp_cnt_o == '0 && grp_o == '0));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_cnt_o <= CNT_W'(SLOT_N));

  // R5
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_o |-> grp_cnt_o == exp_cnt_q);

  for (genvar k = 0; k < SLOT_N; k++) begin : g_tail
    // R6
    tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_cnt_o <= CNT_W'(k)) |-> grp_o[k*INSN_W +: INSN_W] == '0);
  end
endmodule

bind collapse_fetch_buf cfb_chk #(.SLOT_N(SLOT_N), .INSN_W(INSN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_vld_i (fetch_vld_i),
  .off_i       (off_i),
  .slot_vld_i  (slot_vld_i),
  .grp_vld_o   (grp_vld_o),
  .grp_o       (grp_o),
  .grp_cnt_o   (grp_cnt_o)
);

// File: tb/collapse_fetch_buf_tb.sv
`timescale 1ns/1ps
module collapse_fetch_buf_tb;
  localparam int SLOT_N = 4;
  localparam int INSN_W = 32;
  localparam int OFF_W  = $clog2(SLOT_N);
  localparam int CAND_N = 2 * SLOT_N;
  localparam int CNT_W  = $clog2(SLOT_N + 1);
  localparam int LINE_W = SLOT_N * INSN_W;

  typedef struct {
    logic [LINE_W-1:0] grp;
    int                cnt;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fetch_vld_i = 1'b0;
  logic              bank_sel_i = 1'b0;
  logic [OFF_W-1:0]  off_i = '0;
  logic [LINE_W-1:0] bank0_line_i = '0;
  logic [LINE_W-1:0] bank1_line_i = '0;
  logic [CAND_N-1:0] slot_vld_i = '0;
  logic              grp_vld_o;
  logic [LINE_W-1:0] grp_o;
  logic [CNT_W-1:0]  grp_cnt_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 0;
  bit   done = 0;
  exp_t sb[$];

  always #10 clk_i = ~clk_i;

  collapse_fetch_buf #(.SLOT_N(SLOT_N), .INSN_W(INSN_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [INSN_W-1:0] act,
                     input logic [INSN_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input bit sel, input int off, input logic [LINE_W-1:0] b0,
                                 input logic [LINE_W-1:0] b1, input logic [CAND_N-1:0] m);
    exp_t e;
    logic [INSN_W-1:0] c [CAND_N];
    e.grp = '0;
    e.cnt = 0;
    for (int w = 0; w < SLOT_N; w++) begin
      c[w]          = sel ? b1[w*INSN_W +: INSN_W] : b0[w*INSN_W +: INSN_W];
      c[w + SLOT_N] = sel ? b0[w*INSN_W +: INSN_W] : b1[w*INSN_W +: INSN_W];
    end
    for (int j = 0; j < CAND_N; j++) begin
      if (m[j] && !(j < off) && e.cnt < SLOT_N) begin
        e.grp[e.cnt*INSN_W +: INSN_W] = c[j];
        e.cnt++;
      end
    end
    return e;
  endfunction

  task automatic drive(input bit v, input bit sel, input int off, input logic [LINE_W-1:0] b0,
                       input logic [LINE_W-1:0] b1, input logic [CAND_N-1:0] m);
    @(negedge clk_i);
    fetch_vld_i  = v;
    bank_sel_i   = sel;
    off_i        = OFF_W'(off);
    bank0_line_i = b0;
    bank1_line_i = b1;
    slot_vld_i   = m;
    if (v) sb.push_back(model(sel, off, b0, b1, m));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (mon_on) begin
        if (grp_vld_o) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R7", 32'(grp_vld_o), 32'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(int'(grp_cnt_o) == e.cnt, "R5", 32'(grp_cnt_o), 32'(e.cnt));
            for (int k = 0; k < SLOT_N; k++) begin
              if (k < e.cnt)
                chk(grp_o[k*INSN_W +: INSN_W] == e.grp[k*INSN_W +: INSN_W], "R3",
                    grp_o[k*INSN_W +: INSN_W], e.grp[k*INSN_W +: INSN_W]);
              else
                chk(grp_o[k*INSN_W +: INSN_W] == '0, "R6", grp_o[k*INSN_W +: INSN_W], '0);
            end
          end
        end else begin
          // R8: idle cycle leaves empty outputs
          chk(grp_cnt_o == '0 && grp_o == '0, "R8", 32'(grp_cnt_o), 32'd0);
          chk(sb.size() == 0, "R7", 32'(sb.size()), 32'd0);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] a_line, b_line;
    for (int w = 0; w < SLOT_N; w++) begin
      a_line[w*INSN_W +: INSN_W] = 32'hA000_0000 + 32'(w);
      b_line[w*INSN_W +: INSN_W] = 32'hB000_0000 + 32'(w);
    end
    bank0_line_i = a_line;
    bank1_line_i = b_line;
    slot_vld_i   = '1;
    repeat (3) @(negedge clk_i);
    // R9: reset holds outputs at zero
    chk(grp_vld_o == 1'b0, "R9", 32'(grp_vld_o), 32'd0);
    chk(grp_cnt_o == '0, "R9", 32'(grp_cnt_o), 32'd0);
    chk(grp_o == '0, "R9", grp_o[INSN_W-1:0], 32'd0);
    rst_ni = 1'b1;
    mon_on = 1;
    // R1: aligned, both bank orders
    drive(1, 0, 0, a_line, b_line, 8'hFF);
    drive(1, 1, 0, a_line, b_line, 8'hFF);
    // R2: misaligned start fills from next line
    drive(1, 0, 2, a_line, b_line, 8'hFF);
    drive(1, 1, 3, a_line, b_line, 8'hFF);
    // R3/R4: A,B,C,E,G pattern, capped at four
    drive(1, 0, 0, a_line, b_line, 8'b0101_0111);
    drive(1, 0, 0, a_line, b_line, 8'b0000_0101);
    // R2: only valid slot is behind the offset
    drive(1, 0, 3, a_line, b_line, 8'b0000_0010);
    drive(1, 1, 0, a_line, b_line, 8'h00);
    // R8: idle
    drive(0, 0, 0, a_line, b_line, 8'hFF);
    drive(1, 1, 1, a_line, b_line, 8'b1010_0110);
    drive(0, 1, 1, a_line, b_line, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      logic [LINE_W-1:0] r0, r1;
      for (int w = 0; w < SLOT_N; w++) begin
        r0[w*INSN_W +: INSN_W] = $urandom;
        r1[w*INSN_W +: INSN_W] = $urandom;
      end
      drive(($urandom % 5) != 0, 1'($urandom), int'($urandom % SLOT_N), r0, r1,
            CAND_N'($urandom));
    end
    drive(0, 0, 0, a_line, b_line, '0);
    repeat (3) @(negedge clk_i);
    chk(sb.size() == 0, "R7", 32'(sb.size()), 32'd0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule